// File: doc/BRIEF.md
# PSRAM Power-Mode Register Programming Sequencer

This block sits on the host side of a pseudo-static RAM and drives the pins that load the memory's 5-bit power configuration register. On a start request it pulls the active-low sleep pin down with the chip and both byte selects deselected. After a set delay it issues one write pulse whose low five address bits carry the configuration word. It then either releases the sleep pin at once or keeps it low to leave the memory in a low-power standby.

When the memory is left in standby and the configuration has deep sleep enabled, the sequencer treats the array as powered off. It keeps the sleep pin low for a minimum time even if release is requested earlier. After release it holds off new accesses for a recovery period. A shadow copy of the last word written is kept for the host. Because deep sleep makes the memory return its register to the power-up value, the shadow is set to that value when deep sleep starts.

All delays are parameters counted in clock cycles. `busy_o` marks timed phases that cannot be cut short. `ready_o` marks that the memory may be accessed.

Top module: `psq_seq`

## Requirements
- R1: After reset the sleep, chip select, byte select and write strobe pins are all high, the address is zero, `busy_o` is 0, `ready_o` is 1 and `shadow_o` equals `DEF_CFG`.
- R2: A `start_i` pulse taken while ready drives the sleep pin low on the next cycle, with chip select, both byte selects and write strobe all still high in that cycle.
- R3: The write strobe goes low exactly `ZZ_WE_CYC` cycles after the sleep pin goes low.
- R4: The write strobe stays low for exactly `WP_CYC` cycles. During that time chip select and both byte selects are low, address bits 4:0 equal the configuration word captured at start, and all higher address bits are zero.
- R5: After the write strobe rises, the sleep pin stays low for exactly `ZZH_CYC` cycles when `hold_i` was 0 at start. The block then returns to the R1 pin state with `ready_o` 1.
- R6: At the end of the write pulse `shadow_o` takes the captured configuration word.
- R7: With `hold_i` 1 and bit 4 of the word set to 1 (deep sleep disabled), the sleep pin stays low until `wake_i` is seen. During that wait `busy_o` and `ready_o` are both 0.
- R8: With `hold_i` 1 and bit 4 of the word 0 (deep sleep enabled), the sleep pin stays low for at least `ZZH_CYC + DS_MIN_CYC` cycles after the write strobe rises, whatever the timing of `wake_i`.
- R9: On leaving deep sleep the sleep pin goes high, and `busy_o` stays 1 with `ready_o` 0 for exactly `RECOV_CYC` cycles before ready returns.
- R10: Entering deep sleep sets `shadow_o` to `DEF_CFG`.
- R11: `start_i` asserted while not ready is ignored: the word in progress and the shadow result are unchanged.
- R12: `busy_o` is 1 from the cycle the sleep pin falls through the end of the post-write hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a programming command (taken only when ready) |
| cfg_i | input | 5 | Configuration word: 1:0 section, 2 half, 3 array mode, 4 deep sleep disable |
| hold_i | input | 1 | Keep the sleep pin low after the write |
| wake_i | input | 1 | Level request to release the sleep pin from hold |
| zz_no | output | 1 | Sleep pin, active low |
| ce_no | output | 1 | Chip select, active low |
| ub_no | output | 1 | Upper byte select, active low |
| lb_no | output | 1 | Lower byte select, active low |
| we_no | output | 1 | Write strobe, active low |
| addr_o | output | ADDR_W | Address bus carrying the configuration word |
| busy_o | output | 1 | Timed phase in progress |
| ready_o | output | 1 | Memory may be accessed |
| shadow_o | output | 5 | Last known register content |

## Verification
The bench builds the block with `ZZ_WE_CYC`=3, `WP_CYC`=7, `ZZH_CYC`=2, `DS_MIN_CYC`=24 and `RECOV_CYC`=40. With these values a full deep sleep and recovery fits into about a hundred cycles, so dozens of random commands can run. Release requests can then land both before and after the minimum sleep time ends, which exercises the cases where the minimum or the host decides when the sleep pin rises. The default reset word has deep sleep enabled, so any held command whose word clears bit 4 exercises the shadow reset.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int CFG_W  = 5;
  localparam int DS_BIT = 4;  // 0 = deep sleep enabled

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_ZZH,
    ST_HOLD,
    ST_RECOV
  } psq_state_e;
endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import psq_pkg::*;
#(
  parameter int ZZ_WE_CYC  = 10,
  parameter int WP_CYC     = 7,
  parameter int ZZH_CYC    = 3,
  parameter int DS_MIN_CYC = 1000,
  parameter int RECOV_CYC  = 20000,
  parameter int CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic             ds_dis_i,
  input  logic             wake_i,
  input  logic             tmr_done_i,
  output psq_state_e       state_o,
  output logic             deep_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             cap_o,
  output logic             wr_done_o,
  output logic             ds_enter_o
);
  psq_state_e state_q, state_d;
  logic hold_q, deep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
      deep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_o) begin
        hold_q <= hold_i;
        deep_q <= hold_i & ~ds_dis_i;
      end
    end
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cap_o      = 1'b0;
    wr_done_o  = 1'b0;
    ds_enter_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SETUP; tmr_load_o = 1'b1; cap_o = 1'b1;
        tmr_val_o = CNT_W'(ZZ_WE_CYC - 1);
      end
      ST_SETUP: if (tmr_done_i) begin
        state_d = ST_PULSE; tmr_load_o = 1'b1;
        tmr_val_o = CNT_W'(WP_CYC - 1);
      end
      ST_PULSE: if (tmr_done_i) begin
        state_d = ST_ZZH; tmr_load_o = 1'b1; wr_done_o = 1'b1;
        tmr_val_o = CNT_W'(ZZH_CYC - 1);
      end
      ST_ZZH: if (tmr_done_i) begin
        if (hold_q) begin
          state_d = ST_HOLD; tmr_load_o = 1'b1; ds_enter_o = deep_q;
          tmr_val_o = deep_q ? CNT_W'(DS_MIN_CYC - 1) : '0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: if (tmr_done_i && wake_i) begin
        if (deep_q) begin
          state_d = ST_RECOV; tmr_load_o = 1'b1;
          tmr_val_o = CNT_W'(RECOV_CYC - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RECOV: if (tmr_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o = state_q;
  assign deep_o  = deep_q;

  a_r11_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> !cap_o);
  a_r9_recov_after_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV) |-> deep_q);
endmodule

// File: rtl/psq_shadow.sv
module psq_shadow
  import psq_pkg::*;
#(
  parameter logic [CFG_W-1:0] DEF_CFG = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             wr_done_i,
  input  logic             ds_enter_i,
  output logic [CFG_W-1:0] cmd_cfg_o,
  output logic [CFG_W-1:0] shadow_o
);
  logic [CFG_W-1:0] cmd_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      shadow_q <= DEF_CFG;
    end else begin
      if (cap_i)           cmd_q    <= cfg_i;
      if (wr_done_i)       shadow_q <= cmd_q;
      else if (ds_enter_i) shadow_q <= DEF_CFG;  // memory reverts on deep sleep
    end
  end

  assign cmd_cfg_o = cmd_q;
  assign shadow_o  = shadow_q;

  a_r10_deep_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_enter_i |=> shadow_q == DEF_CFG);
endmodule

// File: rtl/psq_seq.sv
module psq_seq
  import psq_pkg::*;
#(
  parameter int                ADDR_W     = 20,
  parameter int                ZZ_WE_CYC  = 10,
  parameter int                WP_CYC     = 7,
  parameter int                ZZH_CYC    = 3,
  parameter int                DS_MIN_CYC = 1000,
  parameter int                RECOV_CYC  = 20000,
  parameter logic [CFG_W-1:0]  DEF_CFG    = 5'b00000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              hold_i,
  input  logic              wake_i,
  output logic              zz_no,
  output logic              ce_no,
  output logic              ub_no,
  output logic              lb_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic [CFG_W-1:0]  shadow_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = max2(max2(ZZ_WE_CYC, WP_CYC),
                                max2(ZZH_CYC, max2(DS_MIN_CYC, RECOV_CYC)));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  psq_state_e       state;
  logic             deep, tmr_load, tmr_done, cap, wr_done, ds_enter;
  logic [CNT_W-1:0] tmr_val;
  logic [CFG_W-1:0] cmd_cfg;

  psq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i (tmr_load), .val_i (tmr_val), .done_o (tmr_done)
  );

  psq_fsm #(
    .ZZ_WE_CYC (ZZ_WE_CYC), .WP_CYC (WP_CYC), .ZZH_CYC (ZZH_CYC),
    .DS_MIN_CYC (DS_MIN_CYC), .RECOV_CYC (RECOV_CYC), .CNT_W (CNT_W)
  ) u_fsm (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .start_i (start_i), .hold_i (hold_i), .ds_dis_i (cfg_i[DS_BIT]),
    .wake_i (wake_i), .tmr_done_i (tmr_done),
    .state_o (state), .deep_o (deep),
    .tmr_load_o (tmr_load), .tmr_val_o (tmr_val),
    .cap_o (cap), .wr_done_o (wr_done), .ds_enter_o (ds_enter)
  );

  psq_shadow #(.DEF_CFG(DEF_CFG)) u_shadow (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .cap_i (cap), .cfg_i (cfg_i), .wr_done_i (wr_done), .ds_enter_i (ds_enter),
    .cmd_cfg_o (cmd_cfg), .shadow_o (shadow_o)
  );

  logic in_write, asleep, drive_addr;
  assign in_write   = (state == ST_PULSE);
  assign asleep     = (state == ST_SETUP) || in_write || (state == ST_ZZH) ||
                      (state == ST_HOLD);
  assign drive_addr = (state == ST_SETUP) || in_write || (state == ST_ZZH);

  assign zz_no   = ~asleep;
  assign we_no   = ~in_write;
  assign ce_no   = ~in_write;
  assign ub_no   = ~in_write;
  assign lb_no   = ~in_write;
  assign addr_o  = drive_addr ? {{(ADDR_W-CFG_W){1'b0}}, cmd_cfg} : '0;
  assign ready_o = (state == ST_IDLE);
  assign busy_o  = !(ready_o || (state == ST_HOLD && tmr_done));

  a_r2_deselect_at_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zz_no) |-> (ce_no && ub_no && lb_no && we_no));
  a_r4_write_inside_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !zz_no);
  a_r4_addr_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> addr_o[ADDR_W-1:CFG_W] == '0);
  a_r4_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> $stable(addr_o));
  a_r12_busy_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> busy_o);
  a_r1_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && zz_no && we_no));
  a_r9_no_ready_when_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deep && $rose(zz_no)) |-> !ready_o);
endmodule

// File: tb/psq_seq_tb_top.sv
module psq_seq_tb_top;
  localparam int ZZ  = 3;
  localparam int WP  = 7;
  localparam int ZH  = 2;
  localparam int DS  = 24;
  localparam int RC  = 40;
  localparam int AW  = 20;
  localparam logic [4:0] DEF = 5'b00000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, hold = 1'b0, wake = 1'b0;
  logic [4:0] cfg = '0;
  logic zz_n, ce_n, ub_n, lb_n, we_n, busy, ready;
  logic [AW-1:0] addr;
  logic [4:0] shadow;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  psq_seq #(
    .ADDR_W (AW), .ZZ_WE_CYC (ZZ), .WP_CYC (WP), .ZZH_CYC (ZH),
    .DS_MIN_CYC (DS), .RECOV_CYC (RC), .DEF_CFG (DEF)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cfg_i (cfg),
    .hold_i (hold), .wake_i (wake), .zz_no (zz_n), .ce_no (ce_n),
    .ub_no (ub_n), .lb_no (lb_n), .we_no (we_n), .addr_o (addr),
    .busy_o (busy), .ready_o (ready), .shadow_o (shadow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // zz-low cycles after the write strobe rises
  function automatic int exp_post(logic [4:0] c, logic h, int w);
    int first = ZZ + WP + ZH;
    int minh  = (!c[4]) ? DS : 1;
    if (!h) return ZH;
    return max2(w + 1, first + minh) - ZZ - WP;
  endfunction

  // cycles with zz low and busy low (the open-ended part of a hold)
  function automatic int exp_idle_hold(logic [4:0] c, logic h, int w);
    int len;
    if (!h) return 0;
    len = exp_post(c, h, w) - ZH;
    return (!c[4]) ? len - (DS - 1) : len;
  endfunction

  task automatic idle_pins(input string tag);
    chk(zz_n && ce_n && ub_n && lb_n && we_n, {tag, " pins high"},
        {zz_n, ce_n, ub_n, lb_n, we_n}, 5'h1F);
    chk(addr == '0, {tag, " addr zero"}, int'(addr), 0);
    chk(ready && !busy, {tag, " ready"}, {ready, busy}, 2);
  endtask

  task automatic run_cmd(input logic [4:0] c, input logic h, input int w);
    int idx = 0, n_setup = 0, n_we = 0, n_post = 0, n_rec = 0, n_bl = 0;
    int sel_err = 0, addr_err = 0;
    bit seen_we = 0, fin = 0;
    logic [4:0] exp_sh;
    @(negedge clk);
    start = 1'b1; cfg = c; hold = h;
    @(negedge clk);
    start = 1'b0;
    while (!fin && idx < 5000) begin
      if (idx == 0) begin
        chk(!zz_n && ce_n && ub_n && lb_n && we_n, "R2 sleep first, deselected",
            {zz_n, ce_n, ub_n, lb_n, we_n}, 5'h0F);
        chk(busy, "R12 busy at sleep entry", busy, 1);
      end
      if (!zz_n && we_n && !seen_we) n_setup++;
      if (!we_n) begin
        seen_we = 1;
        n_we++;
        if (ce_n || ub_n || lb_n) sel_err++;
        if (addr != {{(AW-5){1'b0}}, c}) addr_err++;
      end
      if (!zz_n && we_n && seen_we) begin
        n_post++;
        if (!busy) n_bl++;
        if (ready) sel_err++;
      end
      if (zz_n && busy && seen_we) n_rec++;
      if (ready) fin = 1;
      if (idx == 2) begin start = 1'b1; cfg = ~c; end   // R11 stray start
      else if (idx == 3) start = 1'b0;
      if (idx == w) wake = 1'b1;
      idx++;
      @(negedge clk);
    end
    wake = 1'b0; start = 1'b0;
    chk(fin, "cmd completes", fin, 1);
    chk(n_setup == ZZ, "R3 sleep-to-strobe delay", n_setup, ZZ);
    chk(n_we == WP, "R4 strobe width", n_we, WP);
    chk(sel_err == 0, "R4 selects low in write, not ready while asleep", sel_err, 0);
    chk(addr_err == 0, "R4 R11 address carries captured word", addr_err, 0);
    chk(n_post == exp_post(c, h, w), (h ? (!c[4] ? "R8 deep sleep low time" :
        "R7 hold until wake") : "R5 post-write hold"), n_post, exp_post(c, h, w));
    chk(n_bl == exp_idle_hold(c, h, w), "R7 R12 busy low only in open hold",
        n_bl, exp_idle_hold(c, h, w));
    chk(n_rec == ((h && !c[4]) ? RC : 0), "R9 recovery length", n_rec,
        (h && !c[4]) ? RC : 0);
    exp_sh = (h && !c[4]) ? DEF : c;
    chk(shadow == exp_sh, (h && !c[4]) ? "R10 shadow default" : "R6 R11 shadow",
        int'(shadow), int'(exp_sh));
    idle_pins("R5 after cmd");
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    idle_pins("R1 reset");
    chk(shadow == DEF, "R1 reset shadow", int'(shadow), int'(DEF));
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1 after release");

    run_cmd(5'h1B, 1'b0, 0);      // R5 R6 plain program
    run_cmd(5'h0D, 1'b0, 0);      // deep bit clear but no hold: no deep sleep
    run_cmd(5'h15, 1'b1, 60);     // R7 late wake, no deep sleep
    run_cmd(5'h1E, 1'b1, 0);      // R7 wake already present
    run_cmd(5'h03, 1'b1, 0);      // R8 early wake, minimum decides
    run_cmd(5'h0A, 1'b1, 80);     // R8 R9 R10 late wake from deep sleep
    run_cmd(5'h1F, 1'b0, 0);

    for (int i = 0; i < 24; i++) begin
      logic [4:0] c = 5'($urandom);
      logic       h = 1'($urandom);
      int         w = int'($urandom % 70);
      run_cmd(c, h, w);
    end
    finish_run();
  end
endmodule